// File: doc/BRIEF.md
# RTC Shadow Register Access Controller

This block sits between a byte-wide processor register bus and a free-running real-time clock counter. It keeps a shadow copy of the whole-second count, the sub-second remainder and the two rate-trim values (a 17-bit period term P and a 2-bit fine term Q). While no freeze is active, the shadow follows the live counter and the current trim values on every bus clock. The processor can freeze the shadow and read a snapshot that cannot tear between bytes.

For updates, the processor arms a write freeze, stages new time and trim bytes into the shadow, and then drops the write freeze. The controller then waits for the next rising edge of the slow RTC tick. That tick is brought into the bus clock domain through a two-flop synchronizer. On that edge the controller issues one load strobe for the counter and one for the rate logic. The write-freeze status keeps reading 1 until that load has been issued.

A sticky fail flag records count errors reported by the counter. Only the processor can clear it.

Top module: `rtc_shadow_ctrl`

## Requirements
- R1: After reset, the control byte at address 0 reads 0x00, the rate outputs hold P = 0x10000 and Q = 0, and neither load strobe is asserted.
- R2: While the shadow is not frozen, it captures the live seconds and sub-second inputs on every clock. The seconds bytes are read at addresses 2 to 5, least significant byte first, and the sub-second value at address 1.
- R3: Writing 1 to control bit 0 (read freeze) stops the shadow from tracking. Control bit 0 reads 1 whenever the shadow is frozen for any reason and 0 when it is current.
- R4: Writing 0 to control bit 0, with no write freeze or pending commit, lets the shadow resume tracking on the next clock.
- R5: Writes to the seconds bytes and to the rate bytes are ignored unless control bit 1 (write freeze) is set. The rate bytes are P[7:0] at address 6, P[15:8] at address 7, and {Q at bits 2:1, P[16] at bit 0} at address 8.
- R6: With control bit 1 set, the staged bytes read back from the shadow. Clearing bit 1 schedules a commit. On the next synchronized rising tick edge, time_load pulses for one clock with the staged seconds, and rate_load pulses in the same clock while rate_p and rate_q take the staged values.
- R7: After control bit 1 is cleared, it keeps reading 1 until the commit has been issued, and it reads 0 from the clock after that.
- R8: Control bit 2 (fail) is set by count_err and stays set until a control write with bit 2 equal to 0. When count_err arrives in the same clock as such a write, the flag stays set.
- R9: The sub-second field is read-only. A write to address 1 has no effect on it.
- R10: The load strobes are first high after the third rising clock edge that follows the rise of rtc_tick. A tick edge with no commit pending produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| live_time | input | TIME_W | Live whole-second count |
| live_sub | input | 8 | Live sub-second count, LSB 1/128 s |
| count_err | input | 1 | Count error pulse from the counter |
| rtc_tick | input | 1 | Slow RTC tick, asynchronous to clk |
| time_load | output | 1 | One-cycle strobe loading the counter |
| time_load_val | output | TIME_W | Seconds value to load |
| rate_load | output | 1 | One-cycle strobe for the rate logic |
| rate_p | output | 17 | Current period trim |
| rate_q | output | 2 | Current fine trim |

## Verification
The assertions assume that rtc_tick stays at each level for at least three bus clocks, so that every rise passes the synchronizer and gives exactly one edge. They also assume that count_err and the bus signals are synchronous to clk. The bench changes every input on the falling clock edge. It holds each tick level for several clocks and issues one bus access per cycle, so the snapshot-hold and strobe-timing properties are only checked under conditions the block is built for.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

    localparam int P_W    = 17;
    localparam int Q_W    = 2;
    localparam int SUB_W  = 8;
    localparam int BYTE_W = 8;

    localparam logic [P_W-1:0] P_NEUTRAL = 17'h10000;

    typedef struct packed {
        logic [P_W-1:0] p;
        logic [Q_W-1:0] q;
    } rate_t;

    typedef struct packed {
        logic fail;
        logic wr;
        logic rd;
    } ctrl_t;

    function automatic rate_t rate_reset();
        rate_t r;
        r.p = P_NEUTRAL;
        r.q = '0;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] rate_hi_byte(rate_t r);
        return {5'b0, r.q, r.p[P_W-1]};
    endfunction

endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync (
    input  logic clk,
    input  logic rst,
    input  logic tick_async,
    output logic tick_rise
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= tick_async;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign tick_rise = s2_q & ~s3_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_rise |=> !tick_rise); // R10

endmodule

// File: rtl/rtc_commit_ctl.sv
module rtc_commit_ctl
    import rtc_shadow_pkg::*;
#(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_rise,
    input  logic              wr_fall,
    input  logic [TIME_W-1:0] shadow_time,
    input  rate_t             shadow_rate,
    output logic              pending,
    output logic              time_load,
    output logic [TIME_W-1:0] time_load_val,
    output logic              rate_load,
    output rate_t             rate_cur
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q        <= 1'b0;
            time_load     <= 1'b0;
            rate_load     <= 1'b0;
            time_load_val <= '0;
            rate_cur      <= rate_reset();
        end else begin
            time_load <= 1'b0;
            rate_load <= 1'b0;
            if (pend_q && tick_rise) begin
                pend_q        <= 1'b0;
                time_load     <= 1'b1;
                rate_load     <= 1'b1;
                time_load_val <= shadow_time;
                rate_cur      <= shadow_rate;
            end
            if (wr_fall) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign pending = pend_q;

    AST_LOAD_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        time_load |-> $past(pend_q)); // R6
    AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        time_load |-> $past(tick_rise)); // R10
    AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
        !rate_load |-> $stable(rate_cur)); // R6

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_shadow_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [TIME_W-1:0] live_time,
    input  logic [SUB_W-1:0]  live_sub,
    input  logic              count_err,
    input  logic              pending,
    input  rate_t             rate_cur,
    output logic [TIME_W-1:0] shadow_time,
    output rate_t             shadow_rate,
    output logic              wr_fall,
    output logic              wr_status
);
    localparam int TB = TIME_W / BYTE_W;
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SUB   = ADDR_W'(1);
    localparam int                T_BASE  = 2;
    localparam logic [ADDR_W-1:0] A_P_LO  = ADDR_W'(T_BASE + TB);
    localparam logic [ADDR_W-1:0] A_P_MID = ADDR_W'(T_BASE + TB + 1);
    localparam logic [ADDR_W-1:0] A_P_HI  = ADDR_W'(T_BASE + TB + 2);

    ctrl_t            ctrl_q;
    logic [SUB_W-1:0] shadow_sub;
    logic             frozen;
    logic             ctrl_wr;
    logic             fail_clr;

    assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
    assign fail_clr  = ctrl_wr && !bus_wdata[2];
    assign frozen    = ctrl_q.rd | ctrl_q.wr | pending;
    assign wr_fall   = ctrl_wr && ctrl_q.wr && !bus_wdata[1];
    assign wr_status = ctrl_q.wr | pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            shadow_time <= '0;
            shadow_sub  <= '0;
            shadow_rate <= rate_reset();
        end else begin
            if (ctrl_wr) begin
                ctrl_q.rd <= bus_wdata[0];
                ctrl_q.wr <= bus_wdata[1];
            end
            if (count_err) begin
                ctrl_q.fail <= 1'b1;
            end else if (fail_clr) begin
                ctrl_q.fail <= 1'b0;
            end
            if (!frozen) begin
                shadow_time <= live_time;
                shadow_sub  <= live_sub;
                shadow_rate <= rate_cur;
            end else if (bus_wr && ctrl_q.wr) begin
                for (int b = 0; b < TB; b++) begin
                    if (bus_addr == ADDR_W'(T_BASE + b)) begin
                        shadow_time[b*BYTE_W +: BYTE_W] <= bus_wdata;
                    end
                end
                if (bus_addr == A_P_LO)  shadow_rate.p[7:0]  <= bus_wdata;
                if (bus_addr == A_P_MID) shadow_rate.p[15:8] <= bus_wdata;
                if (bus_addr == A_P_HI) begin
                    shadow_rate.p[P_W-1] <= bus_wdata[0];
                    shadow_rate.q        <= bus_wdata[2:1];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)  bus_rdata = {5'b0, ctrl_q.fail, wr_status, frozen};
        if (bus_addr == A_SUB)   bus_rdata = shadow_sub;
        for (int b = 0; b < TB; b++) begin
            if (bus_addr == ADDR_W'(T_BASE + b)) begin
                bus_rdata = shadow_time[b*BYTE_W +: BYTE_W];
            end
        end
        if (bus_addr == A_P_LO)  bus_rdata = shadow_rate.p[7:0];
        if (bus_addr == A_P_MID) bus_rdata = shadow_rate.p[15:8];
        if (bus_addr == A_P_HI)  bus_rdata = rate_hi_byte(shadow_rate);
    end

    AST_TRACK_LIVE: assert property (@(posedge clk) disable iff (rst)
        !frozen |=> (shadow_time == $past(live_time))); // R2
    AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frozen && !(bus_wr && ctrl_q.wr)) |=> $stable(shadow_time)); // R3
    AST_NO_STAGE_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (frozen && !ctrl_q.wr) |=> $stable(shadow_rate)); // R5
    AST_SUB_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        frozen |=> $stable(shadow_sub)); // R9
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.fail && !fail_clr) |=> ctrl_q.fail); // R8

endmodule

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl
    import rtc_shadow_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [TIME_W-1:0] live_time,
    input  logic [7:0]        live_sub,
    input  logic              count_err,
    input  logic              rtc_tick,
    output logic              time_load,
    output logic [TIME_W-1:0] time_load_val,
    output logic              rate_load,
    output logic [16:0]       rate_p,
    output logic [1:0]        rate_q
);
    logic              tick_rise;
    logic              wr_fall;
    logic              wr_status;
    logic              pending;
    logic [TIME_W-1:0] shadow_time;
    rate_t             shadow_rate;
    rate_t             rate_cur;

    rtc_tick_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .tick_async (rtc_tick),
        .tick_rise  (tick_rise)
    );

    rtc_shadow_regs #(.TIME_W(TIME_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .live_time   (live_time),
        .live_sub    (live_sub),
        .count_err   (count_err),
        .pending     (pending),
        .rate_cur    (rate_cur),
        .shadow_time (shadow_time),
        .shadow_rate (shadow_rate),
        .wr_fall     (wr_fall),
        .wr_status   (wr_status)
    );

    rtc_commit_ctl #(.TIME_W(TIME_W)) u_commit (
        .clk           (clk),
        .rst           (rst),
        .tick_rise     (tick_rise),
        .wr_fall       (wr_fall),
        .shadow_time   (shadow_time),
        .shadow_rate   (shadow_rate),
        .pending       (pending),
        .time_load     (time_load),
        .time_load_val (time_load_val),
        .rate_load     (rate_load),
        .rate_cur      (rate_cur)
    );

    assign rate_p = rate_cur.p;
    assign rate_q = rate_cur.q;

    AST_WR_HELD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_status) |-> time_load); // R7
    AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (rst)
        $rose(time_load) |-> $rose(rate_load)); // R6

endmodule

// File: tb/rtc_shadow_ctrl_bench.sv
module rtc_shadow_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] live_time = '0;
    logic [7:0]  live_sub = '0;
    logic        count_err = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        time_load;
    logic [31:0] time_load_val;
    logic        rate_load;
    logic [16:0] rate_p;
    logic [1:0]  rate_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_shadow_ctrl u_rtc_shadow_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .live_time(live_time),
        .live_sub(live_sub), .count_err(count_err), .rtc_tick(rtc_tick),
        .time_load(time_load), .time_load_val(time_load_val),
        .rate_load(rate_load), .rate_p(rate_p), .rate_q(rate_q)
    );

    localparam logic [39:0] VEC [4] = '{
        {32'h0000_0000, 8'd0},
        {32'h0001_0203, 8'd5},
        {32'hDEAD_BEEF, 8'd127},
        {32'h8000_0001, 8'd64}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_time(output logic [31:0] t);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(4'(2 + i), b);
            t[i*8 +: 8] = b;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] t;
        step(3);
        rst = 1'b0;
        // R1 reset state
        rd(0, b);
        check({24'b0, b}, 32'h00, "R1 ctrl");
        check({15'b0, rate_p}, 32'h10000, "R1 rate_p");
        check({30'b0, rate_q}, 32'h0, "R1 rate_q");
        check({31'b0, time_load | rate_load}, 32'h0, "R1 strobes");

        // R2 tracking over the vector table
        for (int i = 0; i < 4; i++) begin
            live_time = VEC[i][39:8];
            live_sub  = VEC[i][7:0];
            step(1);
            rd_time(t);
            check(t, VEC[i][39:8], "R2 seconds");
            rd(1, b);
            check({24'b0, b}, {24'b0, VEC[i][7:0]}, "R2 subsec");
        end

        // R3 read freeze holds snapshot across ticks
        wr(0, 8'h01);
        live_time = 32'h1111_2222; live_sub = 8'd9;
        rtc_tick = 1'b1; step(4); rtc_tick = 1'b0; step(4);
        rd_time(t);
        check(t, 32'h8000_0001, "R3 snapshot held");
        rd(0, b);
        check({24'b0, b}, 32'h01, "R3 frozen status");
        check({31'b0, time_load}, 32'h0, "R10 no load without pending");

        // R5 writes ignored with write freeze low
        wr(2, 8'hAA);
        rd_time(t);
        check(t, 32'h8000_0001, "R5 seconds write ignored");
        wr(6, 8'h55);
        rd(6, b);
        check({24'b0, b}, 32'h00, "R5 rate write ignored");

        // R4 resume
        wr(0, 8'h00);
        step(1);
        rd_time(t);
        check(t, 32'h1111_2222, "R4 resumed seconds");
        rd(0, b);
        check({24'b0, b}, 32'h00, "R4 status current");

        // R6 stage and commit
        wr(0, 8'h02);
        wr(2, 8'h78); wr(3, 8'h56); wr(4, 8'h34); wr(5, 8'h12);
        wr(6, 8'hC0); wr(7, 8'hFF); wr(8, 8'h04);
        live_time = 32'h0BAD_0BAD;
        step(2);
        rd_time(t);
        check(t, 32'h1234_5678, "R6 staged readback");
        wr(0, 8'h00);
        rd(0, b);
        check({24'b0, b}, 32'h03, "R7 write status after clear");
        step(4);
        rd(0, b);
        check({24'b0, b}, 32'h03, "R7 still pending before tick");
        rtc_tick = 1'b1;
        step(1);
        check({31'b0, time_load}, 32'h0, "R10 edge1 no load");
        step(1);
        check({31'b0, time_load}, 32'h0, "R10 edge2 no load");
        step(1);
        check({31'b0, time_load}, 32'h1, "R10 load on edge3");
        check({31'b0, rate_load}, 32'h1, "R6 rate_load");
        check(time_load_val, 32'h1234_5678, "R6 load value");
        check({15'b0, rate_p}, 32'h0FFC0, "R6 rate_p");
        check({30'b0, rate_q}, 32'h2, "R6 rate_q");
        rd(0, b);
        check({24'b0, b}, 32'h00, "R7 status clear after load");
        step(1);
        check({31'b0, time_load}, 32'h0, "R6 single-cycle strobe");
        rtc_tick = 1'b0;
        step(4);
        rtc_tick = 1'b1; step(4);
        check({15'b0, rate_p}, 32'h0FFC0, "R10 idle tick keeps rate");
        rtc_tick = 1'b0; step(2);

        // R8 sticky fail
        count_err = 1'b1; step(1); count_err = 1'b0;
        rd(0, b);
        check({29'b0, b[2:0] & 3'b100}, 32'h4, "R8 fail set");
        wr(0, 8'h04);
        rd(0, b);
        check({29'b0, b[2:0] & 3'b100}, 32'h4, "R8 write 1 keeps");
        wr(0, 8'h00);
        rd(0, b);
        check({29'b0, b[2:0] & 3'b100}, 32'h0, "R8 write 0 clears");
        count_err = 1'b1; wr(0, 8'h00); count_err = 1'b0;
        rd(0, b);
        check({29'b0, b[2:0] & 3'b100}, 32'h4, "R8 set wins over clear");
        wr(0, 8'h00);

        // R9 sub-second read-only
        live_sub = 8'd33; step(1);
        wr(0, 8'h03);
        wr(1, 8'h55);
        rd(1, b);
        check({24'b0, b}, 32'd33, "R9 subsec write ignored");
        wr(0, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule